// File: doc/BRIEF.md
# DDR Read Burst Sequencer

This block models the device-side read path of a double-data-rate memory. It takes READ commands, each carrying a bank, a starting column and an auto-precharge flag. After a selectable CAS latency it produces one data word for the rising half and one for the falling half of each clock. It also produces a strobe with separate enables for strobe and data. Data words come from a fixed arithmetic function of bank and column, so every element can be predicted. A READ may arrive in any cycle after an earlier one. The newer command then either cuts the running burst short or follows it with no gap on the bus.

The output side is a stream whose valid flag is `dq_oe`. It has no ready signal, because a memory device cannot hold back read data. The receiver must accept one word pair in every cycle in which `dq_oe` is high. Commands on `cmd_valid` are likewise always accepted, so there is no back-pressure anywhere. The latency mode (`mode_cl`) and the burst mode (`mode_bl`) are plain control pins. They are changed only while no burst is in flight and no command is in the latency pipe.

Top module: `ddr_rd_seq`

## Requirements
- R1: A READ sampled at rising edge k puts its first word pair on `dq_rise`/`dq_fall` with `dq_oe`=1 from edge k+CL, where CL is 2 when `mode_cl`=0 and 3 when `mode_cl`=1. Each further pair follows one cycle later.
- R2: In the cycle just before a burst's first pair, if no earlier burst has data in that cycle, `dqs_oe`=1, `dq_oe`=0 and `dqs_rise_lvl`=0. This is the LOW strobe preamble.
- R3: In every data cycle `dqs_oe`=1 and `dqs_rise_lvl`=1. The strobe is HIGH in the rising half and LOW in the falling half, so the last element of a burst always coincides with a LOW strobe (the postamble).
- R4: In any cycle with no data, `dq_oe`=0 and both data words read 0, which models the high-impedance bus. When neither data nor preamble is due, `dqs_oe`=0 as well.
- R5: A READ issued x cycles after the previous READ lets the earlier burst deliver min(x, BL/2) pairs. The new burst's first pair follows in the next cycle if x ≤ BL/2, so the data flow is unbroken.
- R6: Within a burst of BL elements, element e reads column (c with its low log2(BL) bits replaced by (c+e) mod BL), where c is the starting column. Element 2p goes on the rising half of pair p and element 2p+1 on its falling half.
- R7: The word of bank b, column c is ((b·2^CW + c)·7 + 3) mod 2^DW.
- R8: When a READ with auto-precharge delivers its final pair, `pre_valid`=1 and `pre_bank`=b in that same cycle.
- R9: A burst cut short by a newer READ raises no `pre_valid`, and a READ without auto-precharge never raises it.
- R10: While `rst_n` is low, every output is 0 and any command in flight is discarded.
- R11: `mode_bl` = 0, 1 and 2 select BL = 2, 4 and 8, that is 1, 2 and 4 pairs per burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | READ command present this cycle |
| cmd_bank | input | BW | Bank of the READ |
| cmd_col | input | CW | Starting column of the READ |
| cmd_ap | input | 1 | Auto-precharge at burst completion |
| mode_cl | input | 1 | Latency select: 0 = CL2, 1 = CL3 |
| mode_bl | input | 2 | Burst select: 0 = BL2, 1 = BL4, 2 = BL8 |
| dq_rise | output | DW | Data element of the rising half |
| dq_fall | output | DW | Data element of the falling half |
| dq_oe | output | 1 | Data drive enable (stream valid) |
| dqs_oe | output | 1 | Strobe drive enable |
| dqs_rise_lvl | output | 1 | Strobe level in the rising half (falling half is LOW) |
| pre_valid | output | 1 | Row of `pre_bank` becomes precharged |
| pre_bank | output | BW | Bank being precharged |

## Verification
The latency checks assume that `mode_cl` stays fixed from a READ until its first data. They also assume that `mode_bl` never takes the value 3. The stimulus changes both modes only after a quiet stretch that is longer than the largest latency plus burst. It keeps every command inside a planned schedule for each configuration. That schedule sweeps every starting offset within the burst block, and every spacing from back-to-back up to two cycles past a full burst.

// File: rtl/ddr_rd_pkg.sv
package ddr_rd_pkg;

  // burst-length select codes on mode_bl
  typedef enum logic [1:0] {
    BURST2 = 2'd0,
    BURST4 = 2'd1,
    BURST8 = 2'd2
  } burst_e;

  // code 3 is outside the contract; fold it onto the longest burst
  function automatic logic [1:0] burst_code(input logic [1:0] m);
    return (m == 2'd3) ? 2'(BURST8) : m;
  endfunction

endpackage

// File: rtl/rd_cmd_pipe.sv
module rd_cmd_pipe #(
  parameter int W      = 12,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         stg_valid [STAGES],
  output logic [W-1:0] stg_data  [STAGES]
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic         nxt_v;
    logic [W-1:0] nxt_d;
    if (g == 0) begin : g_head
      assign nxt_v = in_valid;
      assign nxt_d = in_data;
    end else begin : g_tail
      assign nxt_v = stg_valid[g-1];
      assign nxt_d = stg_data[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_valid[g] <= 1'b0;
        stg_data[g]  <= '0;
      end else begin
        stg_valid[g] <= nxt_v;
        stg_data[g]  <= nxt_v ? nxt_d : '0;
      end
    end
  end

endmodule

// File: rtl/rd_word_gen.sv
module rd_word_gen #(
  parameter int BW  = 2,
  parameter int CW  = 9,
  parameter int DW  = 16,
  parameter int MUL = 7,
  parameter int ADD = 3
) (
  input  logic [BW-1:0] bank,
  input  logic [CW-1:0] col,
  output logic [DW-1:0] word
);

  localparam int LW = BW + CW;

  logic [LW-1:0] lin;
  assign lin  = {bank, col};
  assign word = DW'(lin) * DW'(MUL) + DW'(ADD);

endmodule

// File: rtl/rd_burst_engine.sv
module rd_burst_engine
  import ddr_rd_pkg::*;
#(
  parameter int BW     = 2,
  parameter int CW     = 9,
  parameter int DW     = 16,
  parameter int MAX_LG = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [BW-1:0] l_bank,
  input  logic [CW-1:0] l_col,
  input  logic          l_ap,
  input  logic          pre_req,
  input  logic [1:0]    bl_sel,
  input  logic [DW-1:0] w_rise,
  input  logic [DW-1:0] w_fall,
  output logic [BW-1:0] rd_bank,
  output logic [CW-1:0] col_rise,
  output logic [CW-1:0] col_fall,
  output logic [DW-1:0] dq_rise,
  output logic [DW-1:0] dq_fall,
  output logic          dq_oe,
  output logic          dqs_oe,
  output logic          strb_hi,
  output logic          pre_valid,
  output logic [BW-1:0] pre_bank
);

  localparam int PW = MAX_LG;
  localparam int EW = MAX_LG + 1;

  logic [BW-1:0] act_bank;
  logic [CW-1:0] act_col;
  logic          act_ap;
  logic [PW-1:0] nxt_pair, left;

  logic [1:0]    code;
  logic [PW-1:0] npairs;
  logic [CW-1:0] mask;

  logic          emit, final_pair;
  logic [BW-1:0] use_bank;
  logic [CW-1:0] use_col;
  logic          use_ap;
  logic [PW-1:0] use_pair, use_left;
  logic [EW-1:0] e_rise, e_fall;

  assign code   = burst_code(bl_sel);
  assign npairs = PW'(1) << code;
  assign mask   = (CW'(1) << (code + 2'd1)) - CW'(1);

  always_comb begin
    emit     = 1'b0;
    use_bank = act_bank;
    use_col  = act_col;
    use_ap   = act_ap;
    use_pair = nxt_pair;
    use_left = '0;
    if (launch) begin
      emit     = 1'b1;
      use_bank = l_bank;
      use_col  = l_col;
      use_ap   = l_ap;
      use_pair = '0;
      use_left = npairs - PW'(1);
    end else if (left != '0) begin
      emit     = 1'b1;
      use_left = left - PW'(1);
    end
    final_pair = emit && (use_left == '0);
  end

  assign e_rise   = {use_pair, 1'b0};
  assign e_fall   = {use_pair, 1'b1};
  assign col_rise = (use_col & ~mask) | ((use_col + CW'(e_rise)) & mask);
  assign col_fall = (use_col & ~mask) | ((use_col + CW'(e_fall)) & mask);
  assign rd_bank  = use_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_bank  <= '0;
      act_col   <= '0;
      act_ap    <= 1'b0;
      nxt_pair  <= '0;
      left      <= '0;
      dq_rise   <= '0;
      dq_fall   <= '0;
      dq_oe     <= 1'b0;
      dqs_oe    <= 1'b0;
      strb_hi   <= 1'b0;
      pre_valid <= 1'b0;
      pre_bank  <= '0;
    end else begin
      act_bank  <= use_bank;
      act_col   <= use_col;
      act_ap    <= use_ap;
      nxt_pair  <= use_pair + PW'(1);
      left      <= use_left;
      dq_rise   <= emit ? w_rise : '0;
      dq_fall   <= emit ? w_fall : '0;
      dq_oe     <= emit;
      dqs_oe    <= emit | pre_req;
      strb_hi   <= emit;
      pre_valid <= final_pair & use_ap;
      pre_bank  <= (final_pair & use_ap) ? use_bank : '0;
    end
  end

endmodule

// File: rtl/ddr_rd_seq.sv
module ddr_rd_seq #(
  parameter int BW     = 2,
  parameter int CW     = 9,
  parameter int DW     = 16,
  parameter int CL_MIN = 2,
  parameter int MAX_LG = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [BW-1:0] cmd_bank,
  input  logic [CW-1:0] cmd_col,
  input  logic          cmd_ap,
  input  logic          mode_cl,
  input  logic [1:0]    mode_bl,
  output logic [DW-1:0] dq_rise,
  output logic [DW-1:0] dq_fall,
  output logic          dq_oe,
  output logic          dqs_oe,
  output logic          dqs_rise_lvl,
  output logic          pre_valid,
  output logic [BW-1:0] pre_bank
);

  localparam int NCL = 2;
  localparam int STG = CL_MIN + NCL - 1;
  localparam int PLW = BW + CW + 1;

  logic           stg_v [STG];
  logic [PLW-1:0] stg_d [STG];

  rd_cmd_pipe #(.W(PLW), .STAGES(STG)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (cmd_valid),
    .in_data  ({cmd_bank, cmd_col, cmd_ap}),
    .stg_valid(stg_v),
    .stg_data (stg_d)
  );

  // taps: preamble one stage ahead of launch
  logic           launch, pre_req;
  logic [PLW-1:0] l_cmd;
  always_comb begin
    launch  = stg_v[CL_MIN - 1 + int'(mode_cl)];
    l_cmd   = stg_d[CL_MIN - 1 + int'(mode_cl)];
    pre_req = stg_v[CL_MIN - 2 + int'(mode_cl)];
  end

  logic [BW-1:0] rd_bank;
  logic [CW-1:0] lane_col  [2];
  logic [DW-1:0] lane_word [2];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    rd_word_gen #(.BW(BW), .CW(CW), .DW(DW)) u_word (
      .bank(rd_bank),
      .col (lane_col[g]),
      .word(lane_word[g])
    );
  end

  rd_burst_engine #(.BW(BW), .CW(CW), .DW(DW), .MAX_LG(MAX_LG)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch   (launch),
    .l_bank   (l_cmd[PLW-1 -: BW]),
    .l_col    (l_cmd[CW:1]),
    .l_ap     (l_cmd[0]),
    .pre_req  (pre_req),
    .bl_sel   (mode_bl),
    .w_rise   (lane_word[0]),
    .w_fall   (lane_word[1]),
    .rd_bank  (rd_bank),
    .col_rise (lane_col[0]),
    .col_fall (lane_col[1]),
    .dq_rise  (dq_rise),
    .dq_fall  (dq_fall),
    .dq_oe    (dq_oe),
    .dqs_oe   (dqs_oe),
    .strb_hi  (dqs_rise_lvl),
    .pre_valid(pre_valid),
    .pre_bank (pre_bank)
  );

endmodule

// File: rtl/ddr_rd_seq_chk.sv
module ddr_rd_seq_chk #(
  parameter int BW = 2,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          mode_cl,
  input logic [DW-1:0] dq_rise,
  input logic [DW-1:0] dq_fall,
  input logic          dq_oe,
  input logic          dqs_oe,
  input logic          dqs_rise_lvl,
  input logic          pre_valid,
  input logic [BW-1:0] pre_bank
);

  // R1
  cl2_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !mode_cl |-> ##3 dq_oe);

  // R1
  cl3_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && mode_cl |-> ##4 dq_oe);

  // R2
  cl2_preamble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !mode_cl |-> ##2 dqs_oe);

  // R2
  preamble_then_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_oe && !dq_oe |=> dq_oe);

  // R3
  strobe_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> dqs_oe && dqs_rise_lvl);

  // R4
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> dq_rise == '0 && dq_fall == '0 && !dqs_rise_lvl);

  // R8
  precharge_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_valid |-> dq_oe);

  // R9
  precharge_bank_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_valid |-> pre_bank == '0);

endmodule

bind ddr_rd_seq ddr_rd_seq_chk #(.BW(BW), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .mode_cl     (mode_cl),
  .dq_rise     (dq_rise),
  .dq_fall     (dq_fall),
  .dq_oe       (dq_oe),
  .dqs_oe      (dqs_oe),
  .dqs_rise_lvl(dqs_rise_lvl),
  .pre_valid   (pre_valid),
  .pre_bank    (pre_bank)
);

// File: tb/sim_ddr_rd_seq.sv
`timescale 1ns/1ps
module sim_ddr_rd_seq;

  localparam int BW = 2;
  localparam int CW = 9;
  localparam int DW = 16;
  localparam int NS = 128;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [BW-1:0] cmd_bank = '0;
  logic [CW-1:0] cmd_col = '0;
  logic          cmd_ap = 1'b0;
  logic          mode_cl = 1'b0;
  logic [1:0]    mode_bl = 2'd0;
  logic [DW-1:0] dq_rise, dq_fall;
  logic          dq_oe, dqs_oe, dqs_rise_lvl, pre_valid;
  logic [BW-1:0] pre_bank;

  always #2 clk = ~clk;

  ddr_rd_seq #(.BW(BW), .CW(CW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_bank(cmd_bank),
    .cmd_col(cmd_col), .cmd_ap(cmd_ap), .mode_cl(mode_cl), .mode_bl(mode_bl),
    .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe), .dqs_oe(dqs_oe),
    .dqs_rise_lvl(dqs_rise_lvl), .pre_valid(pre_valid), .pre_bank(pre_bank)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // command plan
  int nc;
  int ct [16];
  int cb [16];
  int cc [16];
  bit ca [16];

  // expectations per negedge slot
  bit e_oe [NS];
  bit e_soe [NS];
  int e_dr [NS];
  int e_df [NS];
  bit e_pv [NS];
  int e_pb [NS];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // R7: word of bank b, column c
  function automatic int word_of(input int b, input int c);
    return ((b * 512 + c) * 7 + 3) & 16'hFFFF;
  endfunction

  // R6: column of element e within a burst of 2^lg elements
  function automatic int col_of(input int c, input int e, input int lg);
    int m = (1 << lg) - 1;
    return (c & ~m & 511) | ((c + e) & m);
  endfunction

  task automatic plan(input int cl, input int lgp);
    int blp = 1 << lgp;
    for (int s = 0; s < NS; s++) begin
      e_oe[s] = 0; e_soe[s] = 0; e_dr[s] = 0; e_df[s] = 0; e_pv[s] = 0; e_pb[s] = 0;
    end
    for (int i = 0; i < nc; i++) begin
      int st = ct[i] + 1 + cl;
      int lim = blp;
      if (i + 1 < nc && ct[i+1] - ct[i] < blp) lim = ct[i+1] - ct[i];
      if (!e_oe[st-1]) e_soe[st-1] = 1;
      for (int p = 0; p < lim; p++) begin
        e_oe[st+p]  = 1;
        e_soe[st+p] = 1;
        e_dr[st+p]  = word_of(cb[i], col_of(cc[i], 2*p, lgp + 1));
        e_df[st+p]  = word_of(cb[i], col_of(cc[i], 2*p + 1, lgp + 1));
      end
      if (lim == blp && ca[i]) begin
        e_pv[st+blp-1] = 1;
        e_pb[st+blp-1] = cb[i];
      end
    end
  endtask

  task automatic run(input int clm, input int blm);
    int cl = 2 + clm;
    int blp = 1 << blm;
    int len = ct[nc-1] + cl + blp + 6;
    int k = 0;
    mode_cl = clm[0];
    mode_bl = blm[1:0];
    plan(cl, blm);
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      chk(dq_oe == e_oe[t], $sformatf("R1/R5 dq_oe cl=%0d bl=%0d t=%0d", cl, 2*blp, t), dq_oe, e_oe[t]);
      chk(dqs_oe == e_soe[t], $sformatf("R2/R4 dqs_oe cl=%0d bl=%0d t=%0d", cl, 2*blp, t), dqs_oe, e_soe[t]);
      chk(dqs_rise_lvl == e_oe[t], $sformatf("R3 strobe level t=%0d", t), dqs_rise_lvl, e_oe[t]);
      chk(int'(dq_rise) == e_dr[t], $sformatf("R6/R7 rise word bl=%0d t=%0d", 2*blp, t), dq_rise, e_dr[t]);
      chk(int'(dq_fall) == e_df[t], $sformatf("R6/R7 fall word bl=%0d t=%0d", 2*blp, t), dq_fall, e_df[t]);
      chk(pre_valid == e_pv[t], $sformatf("R8/R9 pre_valid t=%0d", t), pre_valid, e_pv[t]);
      chk(int'(pre_bank) == e_pb[t], $sformatf("R8 pre_bank t=%0d", t), pre_bank, e_pb[t]);
      if (k < nc && ct[k] == t) begin
        cmd_valid = 1'b1;
        cmd_bank  = cb[k][BW-1:0];
        cmd_col   = cc[k][CW-1:0];
        cmd_ap    = ca[k];
        k++;
      end else begin
        cmd_valid = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(dq_oe == 0 && dqs_oe == 0 && dqs_rise_lvl == 0 && pre_valid == 0, "R10 reset enables",
        {dq_oe, dqs_oe, dqs_rise_lvl, pre_valid}, 0);
    chk(dq_rise == 0 && dq_fall == 0 && pre_bank == 0, "R10 reset data", dq_rise | dq_fall, 0);
    rst_n = 1'b1;

    for (int clm = 0; clm < 2; clm++) begin
      for (int blm = 0; blm < 3; blm++) begin
        int blp = 1 << blm;
        // R6 R11: isolated bursts, every start offset in the block, R8/R9 by ap
        nc = 2 * blp;
        for (int s = 0; s < nc; s++) begin
          ct[s] = s * (blp + 3);
          cb[s] = s % 4;
          cc[s] = (s * 64 + s) & 511;
          ca[s] = s[0];
        end
        run(clm, blm);
        // R5 R9: spacing 1 .. blp+2 between successive reads
        nc = blp + 3;
        ct[0] = 0;
        for (int i = 0; i < nc; i++) begin
          if (i > 0) ct[i] = ct[i-1] + i;
          cb[i] = (i + 1) % 4;
          cc[i] = (i * 53 + 3) & 511;
          ca[i] = (i != 1);
        end
        run(clm, blm);
      end
    end

    // R10: reset in the middle of a burst
    mode_cl = 1'b0;
    mode_bl = 2'd2;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_bank = 2'd3; cmd_col = 9'd17; cmd_ap = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(dq_oe == 1, "R10 burst running before reset", dq_oe, 1);
    rst_n = 1'b0;
    #0.5;
    chk(dq_oe == 0 && dqs_oe == 0 && dq_rise == 0 && pre_valid == 0, "R10 outputs cleared by reset",
        {dq_oe, dqs_oe, pre_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      chk(dq_oe == 0 && dqs_oe == 0 && pre_valid == 0, "R10 discarded command stays silent",
          {dq_oe, dqs_oe, pre_valid}, 0);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule